// File: doc/BRIEF.md
# Auto-Waking Gated Clock Divider

This block derives a slow clock for a configuration port from a fast interface clock. A 3-bit divisor held in a 32-bit software register selects the output. A value of zero stops the output clock. A value of one passes the interface clock straight through. Any value from two to seven divides the interface clock by that value.

Divisor changes are applied only when the current output period ends, so the output never carries a truncated pulse. When the clock is stopped and an agent asks for a configuration access, the block restarts the clock on its own at the slowest rate. It also writes that rate back into the register, so software can read it. Software may then write a smaller divisor to shorten access latency.

The access request uses a valid/ready handshake. The requester raises `acc_valid_i` and holds it until a cycle in which `acc_ready_o` is also high; the transfer happens at that rising edge of `clk_i`. While the output clock is stopped, the block holds `acc_ready_o` low, which keeps the access waiting until the woken clock delivers its first rising edge.

Top module: `cfg_clk_gen`

## Requirements
- R1: The divisor field sits in bits [2:0] of the register and resets to 0. Bits [31:3] read as zero, and writing them has no effect on the field or the clock.
- R2: While the applied divisor is 0, `cfg_clk_o` stays low in both halves of every input cycle.
- R3: While the applied divisor is 1, `cfg_clk_o` is high in the high half of each input cycle and low in the low half.
- R4: For an applied divisor N from 2 to 7, the output period is N input cycles. The first floor(N/2) cycles are high and the rest are low.
- R5: A newly written divisor takes effect only after the output period in progress has completed. That period keeps its old high and low lengths.
- R6: If `acc_valid_i` is sampled high while the field holds 0 and no write occurs in that cycle, the field reads 7 after that edge.
- R7: A software write in the same cycle as a wake condition wins, so the field takes the written value.
- R8: `acc_ready_o` is low after reset and whenever the output clock has stopped. It rises at the same input edge as the first rising edge of the output clock, and it stays high while the clock runs. After a wake from the stopped state, the output first rises two input edges after the edge that sampled the request.
- R9: The field changes only through a software write or a wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast interface clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| acc_valid_i | input | 1 | Configuration access request |
| acc_ready_o | output | 1 | Access may proceed (output clock live) |
| cfg_clk_o | output | 1 | Divided configuration clock |

## Verification
The bench wakes the stopped clock and checks the readback of 7, the two-edge latency and the point at which ready rises. A design that forgot to update the field, or that released ready before the clock ran, fails there. It writes a small divisor in the middle of a slow period and checks that the old period finishes intact; a design that switches at once shows a clipped high or low phase. It raises a write of zero together with a request while stopped, which catches a design that lets the wake override software. Writes with all upper bits set catch any leakage of those bits into the field.

// File: rtl/cfgclk_pkg.sv
package cfgclk_pkg;

  localparam int unsigned DIV_W  = 3;
  localparam int unsigned DATA_W = 32;

  // Per-cycle description of the output waveform, produced one input
  // cycle ahead of the output itself.
  typedef struct packed {
    logic lvl;    // output held high for the whole cycle
    logic byp;    // output follows the input clock this cycle
    logic rise;   // a rising output edge opens this cycle
    logic gated;  // no output edges this cycle
  } phase_t;

endpackage

// File: rtl/cfgclk_field_reg.sv
module cfgclk_field_reg #(
  parameter int unsigned DATA_W    = cfgclk_pkg::DATA_W,
  parameter int unsigned DIV_W     = cfgclk_pkg::DIV_W,
  parameter int unsigned FIELD_LSB = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              acc_valid_i,
  output logic [DIV_W-1:0]  div_o,
  output logic [DATA_W-1:0] rdata_o
);

  localparam logic [DIV_W-1:0] WAKE_DIV = '1;

  logic [DIV_W-1:0] div_q;
  logic             wake;
  logic             unused_wdata;

  assign wake = (div_q == '0) && acc_valid_i;
  assign unused_wdata = ^wdata_i;

  // Software write takes priority over the hardware wake.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
    end else if (wr_i) begin
      div_q <= wdata_i[FIELD_LSB +: DIV_W];
    end else if (wake) begin
      div_q <= WAKE_DIV;
    end
  end

  always_comb begin
    rdata_o = '0;
    rdata_o[FIELD_LSB +: DIV_W] = div_q;
  end

  assign div_o = div_q;

endmodule

// File: rtl/cfgclk_div_core.sv
module cfgclk_div_core #(
  parameter int unsigned DIV_W = cfgclk_pkg::DIV_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [DIV_W-1:0]    div_i,
  output cfgclk_pkg::phase_t  phase_o
);

  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);
  localparam logic [DIV_W-1:0] TWO = DIV_W'(2);

  logic [DIV_W-1:0] cur_q;
  logic [DIV_W-1:0] cnt_q;
  logic             period_end;
  logic             divided;

  assign divided    = (cur_q >= TWO);
  assign period_end = !divided || (cnt_q == cur_q - ONE);

  // The divisor in force is replaced only when its period completes.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '0;
      cnt_q <= '0;
    end else if (period_end) begin
      cur_q <= div_i;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + ONE;
    end
  end

  always_comb begin
    phase_o.lvl   = divided && (cnt_q < (cur_q >> 1));
    phase_o.byp   = (cur_q == ONE);
    phase_o.rise  = (cur_q == ONE) || (divided && (cnt_q == '0));
    phase_o.gated = (cur_q == '0);
  end

endmodule

// File: rtl/cfgclk_out_stage.sv
module cfgclk_out_stage (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  cfgclk_pkg::phase_t phase_i,
  output logic               clk_o
);

  logic lvl_q;
  logic byp_q;

  // Whole-cycle level: changes only at rising input edges.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
    end else begin
      lvl_q <= phase_i.lvl;
    end
  end

  // Pass-through enable: changes only while the input clock is low.
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byp_q <= 1'b0;
    end else begin
      byp_q <= phase_i.byp;
    end
  end

  assign clk_o = lvl_q | (clk_i & byp_q);

endmodule

// File: rtl/cfg_clk_gen.sv
module cfg_clk_gen #(
  parameter int unsigned DATA_W    = cfgclk_pkg::DATA_W,
  parameter int unsigned DIV_W     = cfgclk_pkg::DIV_W,
  parameter int unsigned FIELD_LSB = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              acc_valid_i,
  output logic              acc_ready_o,
  output logic              cfg_clk_o
);

  logic [DIV_W-1:0]   div;
  cfgclk_pkg::phase_t phase;
  logic               ready_q;

  cfgclk_field_reg #(
    .DATA_W    (DATA_W),
    .DIV_W     (DIV_W),
    .FIELD_LSB (FIELD_LSB)
  ) u_field (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (reg_wr_i),
    .wdata_i     (reg_wdata_i),
    .acc_valid_i (acc_valid_i),
    .div_o       (div),
    .rdata_o     (reg_rdata_o)
  );

  cfgclk_div_core #(
    .DIV_W (DIV_W)
  ) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .div_i   (div),
    .phase_o (phase)
  );

  cfgclk_out_stage u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .phase_i (phase),
    .clk_o   (cfg_clk_o)
  );

  // Ready follows the output stage: it is set at the edge that starts the
  // first output pulse and cleared at the edge where the output stops.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q <= 1'b0;
    end else if (phase.gated) begin
      ready_q <= 1'b0;
    end else if (phase.rise) begin
      ready_q <= 1'b1;
    end
  end

  assign acc_ready_o = ready_q;

endmodule

// File: rtl/cfg_clk_gen_chk.sv
module cfg_clk_gen_chk #(
  parameter int unsigned DATA_W    = cfgclk_pkg::DATA_W,
  parameter int unsigned DIV_W     = cfgclk_pkg::DIV_W,
  parameter int unsigned FIELD_LSB = 0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_wr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic              acc_valid_i,
  input logic              acc_ready_o,
  input logic              cfg_clk_o
);

  localparam int unsigned QUIET_CYC = (1 << DIV_W) + 2;
  localparam int unsigned ZC_W      = $clog2(QUIET_CYC + 1);

  logic [DIV_W-1:0] fld;
  logic [DIV_W-1:0] wfld;
  logic [ZC_W-1:0]  zero_cnt;
  logic             unused_bits;

  assign fld  = reg_rdata_o[FIELD_LSB +: DIV_W];
  assign wfld = reg_wdata_i[FIELD_LSB +: DIV_W];
  assign unused_bits = ^{reg_rdata_o, reg_wdata_i};

  // Counts consecutive cycles with a zero field, saturating.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      zero_cnt <= '0;
    end else if (fld != '0) begin
      zero_cnt <= '0;
    end else if (zero_cnt < ZC_W'(QUIET_CYC)) begin
      zero_cnt <= zero_cnt + 1'b1;
    end
  end

  // R6
  a_r6_wake_loads_slowest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fld == '0 && acc_valid_i && !reg_wr_i) |=> (fld == '1));

  // R7
  a_r7_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i |=> (fld == $past(wfld)));

  // R9
  a_r9_field_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reg_wr_i && !(fld == '0 && acc_valid_i)) |=> $stable(fld));

  // R2
  a_r2_gated_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_cnt >= ZC_W'(QUIET_CYC)) |-> !cfg_clk_o);

  // R8
  a_r8_ready_drops_with_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(acc_ready_o) |-> !cfg_clk_o);

endmodule

bind cfg_clk_gen cfg_clk_gen_chk #(
  .DATA_W    (DATA_W),
  .DIV_W     (DIV_W),
  .FIELD_LSB (FIELD_LSB)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_wr_i    (reg_wr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .acc_valid_i (acc_valid_i),
  .acc_ready_o (acc_ready_o),
  .cfg_clk_o   (cfg_clk_o)
);

// File: tb/cfg_clk_gen_bench.sv
`timescale 1ns/1ps
module cfg_clk_gen_bench;

  localparam int T = 8;
  localparam int NVEC = 6;
  localparam int VEC_DIV [NVEC] = '{2, 3, 4, 5, 6, 7};
  localparam int VEC_HI  [NVEC] = '{1, 1, 2, 2, 3, 3};
  localparam int VEC_LO  [NVEC] = '{1, 2, 2, 3, 3, 4};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        valid = 1'b0;
  logic        ready;
  logic        cclk;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(T/2) clk = ~clk;

  cfg_clk_gen u_cfg_clk_gen (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .reg_wr_i    (wr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .acc_valid_i (valid),
    .acc_ready_o (ready),
    .cfg_clk_o   (cclk)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Sample point: a quarter period after a rising input edge (high half).
  task automatic hi_sample(output int s);
    @(posedge clk);
    #(T/4);
    s = int'(cclk);
  endtask

  task automatic reg_write(input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1;
    wdata = d;
    @(negedge clk);
    wr = 1'b0;
    wdata = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  // Finds an output rising edge, then counts the high and low cycles of
  // that period.
  task automatic measure(output int hi, output int lo);
    int s;
    int g;
    g = 0;
    hi_sample(s);
    while (s != 0 && g < 64) begin hi_sample(s); g++; end
    while (s != 1 && g < 64) begin hi_sample(s); g++; end
    hi = 0;
    while (s == 1 && g < 64) begin hi++; hi_sample(s); g++; end
    lo = 0;
    while (s == 0 && g < 64) begin lo++; hi_sample(s); g++; end
  endtask

  initial begin
    int s;
    int hi;
    int lo;
    int g;

    // Reset state: R1, R2, R8
    idle(3);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      hi_sample(s);
      check("R2", "stopped after reset, high half", s, 0);
      #(T/2);
      check("R2", "stopped after reset, low half", int'(cclk), 0);
    end
    check("R1", "field after reset", int'(rdata), 0);
    check("R8", "ready after reset", int'(ready), 0);

    // Wake from stopped: R6, R8
    @(negedge clk);
    valid = 1'b1;
    hi_sample(s);
    check("R6", "field after wake edge", int'(rdata), 7);
    check("R8", "output one edge after wake", s, 0);
    check("R8", "ready one edge after wake", int'(ready), 0);
    hi_sample(s);
    check("R8", "output two edges after wake", s, 0);
    check("R8", "ready before first edge", int'(ready), 0);
    hi_sample(s);
    check("R8", "first output rise", s, 1);
    check("R8", "ready at first rise", int'(ready), 1);
    @(negedge clk);
    @(negedge clk);
    valid = 1'b0;
    measure(hi, lo);
    check("R4", "woken period high", hi, 3);
    check("R4", "woken period low", lo, 4);
    check("R8", "ready while running", int'(ready), 1);

    // Divisor table: R4
    for (int v = 0; v < NVEC; v++) begin
      reg_write(32'(VEC_DIV[v]));
      idle(20);
      check("R1", "field readback", int'(rdata), VEC_DIV[v]);
      measure(hi, lo);
      check("R4", $sformatf("high cycles div %0d", VEC_DIV[v]), hi, VEC_HI[v]);
      check("R4", $sformatf("low cycles div %0d", VEC_LO[v] + VEC_HI[v]), lo, VEC_LO[v]);
    end

    // Change in mid-period (divisor 7 running): R5
    g = 0;
    hi_sample(s);
    while (s != 0 && g < 64) begin hi_sample(s); g++; end
    while (s != 1 && g < 64) begin hi_sample(s); g++; end
    #(T/4);
    wr = 1'b1;
    wdata = 32'd2;
    hi = 1;
    hi_sample(s);
    #(T/4);
    wr = 1'b0;
    wdata = '0;
    while (s == 1 && g < 64) begin hi++; hi_sample(s); g++; end
    lo = 0;
    while (s == 0 && g < 64) begin lo++; hi_sample(s); g++; end
    check("R5", "old period high kept", hi, 3);
    check("R5", "old period low kept", lo, 4);
    measure(hi, lo);
    check("R5", "new period high", hi, 1);
    check("R5", "new period low", lo, 1);

    // Pass-through: R3
    reg_write(32'd1);
    idle(10);
    for (int i = 0; i < 6; i++) begin
      hi_sample(s);
      check("R3", "pass-through high half", s, 1);
      #(T/2);
      check("R3", "pass-through low half", int'(cclk), 0);
    end
    check("R8", "ready in pass-through", int'(ready), 1);

    // Upper bits ignored: R1
    reg_write(32'hFFFF_FFFD);
    @(negedge clk);
    check("R1", "upper bits masked", int'(rdata), 5);
    idle(20);
    measure(hi, lo);
    check("R1", "clock after masked write, high", hi, 2);
    check("R1", "clock after masked write, low", lo, 3);

    // Stop the clock: R2, R8, R9
    reg_write(32'd0);
    idle(12);
    for (int i = 0; i < 8; i++) begin
      hi_sample(s);
      check("R2", "stopped high half", s, 0);
      #(T/2);
      check("R2", "stopped low half", int'(cclk), 0);
    end
    check("R8", "ready while stopped", int'(ready), 0);
    check("R9", "field holds without write", int'(rdata), 0);

    // Write of zero with a request in the same cycle: R7
    @(negedge clk);
    wr = 1'b1;
    wdata = 32'd0;
    valid = 1'b1;
    @(negedge clk);
    check("R7", "write beats wake", int'(rdata), 0);
    wr = 1'b0;
    @(negedge clk);
    check("R6", "wake once write is gone", int'(rdata), 7);
    valid = 1'b0;
    idle(4);
    @(negedge clk);
    check("R9", "field after wake settles", int'(rdata), 7);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(T * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule